// File: doc/BRIEF.md
# SPI Flash Command Engine

This block is a register-programmed SPI master for a serial flash. It carries out one flash command each time software asks for one. Software loads a command word, which holds the opcode and the 24-bit flash address, and an optional data word. It then writes the control register with a transmit byte count, a receive byte count, a clock selection and the start bit.

The engine pulls chip select low and shifts out up to eight bytes in SPI mode 0. The bytes are the opcode, then the three address bytes, then up to four data bytes. The engine then shifts in up to four response bytes and packs them little-endian into the data register. While the command runs, a busy flag reads as 1. Software polls this flag before it starts a new command and before it reads a result. The register file is frozen for the whole time the flag is set.

Top module: `sflash_cmd_engine`

## Requirements
- R1: After reset all three registers read 0, busy reads 0, chip select is high and SCLK is low.
- R2: Register map, decoded on the byte offset `bus_addr`:
  - Offset 0x0 is control: transmit count in bits 3:0, receive count in bits 7:4, start in bit 8 (always reads 0), busy in bit 16 (read-only), a 2-bit size field in bits 18:17 and a 2-bit clock select in bits 25:24. All other bits read 0.
  - Offset 0x4 is the command word: opcode in bits 7:0, flash address in bits 31:8.
  - Offset 0x8 is the data word.
  - The command word and the data word are fully readable and writable.
- R3: A control write with bit 8 set and a nonzero transmit count, made while idle, starts a command. Busy reads 1 in the first cycle after that write.
- R4: A start request with a transmit count of 0 causes no transfer: busy stays 0 and chip select stays high.
- R5: The transmit bytes are sent in this order, each MSB first:
  - the opcode (command bits 7:0);
  - address bits 23:16, 15:8 and 7:0 (command bits 31:24, 23:16, 15:8);
  - data bytes 7:0, 15:8, 23:16 and 31:24.
  A transmit count above 8 is treated as 8.
- R6: Receive bytes follow the transmit bytes, and MOSI is held at 0 while they arrive. The first received byte lands in data bits 7:0 and the next in bits 15:8, and so on. Bytes beyond the receive count read 0. A receive count above 4 is treated as 4. A receive count of 0 leaves the data register unchanged.
- R7: The bus follows SPI mode 0. SCLK idles low, MISO is sampled on the rising SCLK edge, MOSI changes on the falling edge, and SCLK toggles only while chip select is low.
- R8: Clock select values 0, 1, 2 and 3 give an SCLK period of 2, 4, 8 and 16 system clocks.
- R9: Chip select rises after the last falling SCLK edge of the command. It then stays high for at least one SCLK period before busy clears.
- R10: While busy, every bus write is ignored. This covers a second start request and writes to the command, data and control registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| spi_sclk | output | 1 | SPI serial clock |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The frozen-register and gap-length properties assume two things about the bus. First, clock select changes only through a bus write, so the divider setting holds for a whole command. Second, a received word is loaded only at the end of a command. Both hold because the bus master in the stimulus never needs to race the engine. It always polls the busy bit before it issues a new start or reads a result. The only write it makes during a command is the deliberate R10 probe, and nothing in the design assumes anything about that write. MISO comes from a flash model that presents a fixed byte stream. The model changes MISO right after each rising SCLK edge, so the line is stable long before the engine samples it.

// File: rtl/sfe_pkg.sv
`timescale 1ns/1ps
package sfe_pkg;
    localparam int WORD_W       = 32;
    localparam int ADDR_W       = 4;
    localparam int SEL_W        = 2;
    localparam int CNT_W        = 4;
    localparam int TX_BYTES_MAX = 8;
    localparam int RX_BYTES_MAX = 4;

    localparam int OFS_CTRL = 0;
    localparam int OFS_CMD  = 4;
    localparam int OFS_DATA = 8;
    localparam int BIT_START = 8;

    typedef struct packed {
        logic [SEL_W-1:0] clk_sel;
        logic [1:0]       size;
        logic [CNT_W-1:0] rx_cnt;
        logic [CNT_W-1:0] tx_cnt;
    } ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_GAP
    } seq_e;
endpackage

// File: rtl/sfe_regs.sv
`timescale 1ns/1ps
module sfe_regs
    import sfe_pkg::*;
#(
    parameter int DW = WORD_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          busy,
    input  logic          rx_load,
    input  logic [DW-1:0] rx_word,
    output logic          start,
    output ctrl_t         ctrl,
    output logic [DW-1:0] cmd_word,
    output logic [DW-1:0] data_word
);
    typedef struct packed {
        ctrl_t         ctrl;
        logic [DW-1:0] cmd;
        logic [DW-1:0] data;
    } reg_s;

    reg_s q, d;

    logic sel_ctrl, sel_cmd, sel_data;

    always_comb begin
        sel_ctrl = (bus_addr == AW'(OFS_CTRL));
        sel_cmd  = (bus_addr == AW'(OFS_CMD));
        sel_data = (bus_addr == AW'(OFS_DATA));
    end

    always_comb begin
        d     = q;
        start = 1'b0;
        if (bus_wr && !busy) begin
            if (sel_ctrl) begin
                d.ctrl.tx_cnt  = bus_wdata[3:0];
                d.ctrl.rx_cnt  = bus_wdata[7:4];
                d.ctrl.size    = bus_wdata[18:17];
                d.ctrl.clk_sel = bus_wdata[25:24];
                start          = bus_wdata[BIT_START] && (bus_wdata[3:0] != 4'd0);
            end else if (sel_cmd) begin
                d.cmd = bus_wdata;
            end else if (sel_data) begin
                d.data = bus_wdata;
            end
        end
        if (rx_load) begin
            d.data = rx_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (sel_ctrl) begin
            bus_rdata[3:0]   = q.ctrl.tx_cnt;
            bus_rdata[7:4]   = q.ctrl.rx_cnt;
            bus_rdata[16]    = busy;
            bus_rdata[18:17] = q.ctrl.size;
            bus_rdata[25:24] = q.ctrl.clk_sel;
        end else if (sel_cmd) begin
            bus_rdata = q.cmd;
        end else if (sel_data) begin
            bus_rdata = q.data;
        end
    end

    assign ctrl      = q.ctrl;
    assign cmd_word  = q.cmd;
    assign data_word = q.data;

    // R10: the configuration stays frozen across a write made while busy
    assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_wr) |=> ($stable(q.cmd) && $stable(q.ctrl)));

    // R6: a received word arrives only while a command is still marked busy
    assert_load_in_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_load |-> busy);
endmodule

// File: rtl/sfe_clkdiv.sv
`timescale 1ns/1ps
module sfe_clkdiv #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int MAX_LOG = (1 << SEL_W) - 1;
    localparam int CW      = (MAX_LOG < 1) ? 1 : MAX_LOG;

    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] lim;

    always_comb begin
        lim   = CW'((32'd1 << sel) - 32'd1);
        tick  = run && (cnt_q == lim);
        cnt_d = cnt_q + CW'(1);
        if (!run || tick) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R8: the half-period counter never passes the selected limit
    assert_div_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= lim));

    // R8: each half period restarts from zero
    assert_div_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == '0));
endmodule

// File: rtl/sfe_shifter.sv
`timescale 1ns/1ps
module sfe_shifter
    import sfe_pkg::*;
#(
    parameter int DW     = WORD_W,
    parameter int MAX_TX = TX_BYTES_MAX,
    parameter int MAX_RX = RX_BYTES_MAX,
    parameter int CW     = CNT_W,
    parameter int SW     = SEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] tx_cnt,
    input  logic [CW-1:0] rx_cnt,
    input  logic [DW-1:0] cmd_word,
    input  logic [DW-1:0] data_word,
    input  logic          tick,
    input  logic [SW-1:0] clk_sel,
    input  logic          spi_miso,
    output logic          busy,
    output logic          sclk,
    output logic          cs_n,
    output logic          mosi,
    output logic          rx_load,
    output logic [DW-1:0] rx_word
);
    localparam int TXV_W = 8 * MAX_TX;
    localparam int BIT_W = $clog2(8 * (MAX_TX + MAX_RX) + 1);
    localparam int RXP_W = $clog2(DW);

    typedef struct packed {
        seq_e             st;
        logic             sclk;
        logic             cs_n;
        logic             gap_half;
        logic             rx_en;
        logic [BIT_W-1:0] bit_idx;
        logic [BIT_W-1:0] tx_bits;
        logic [BIT_W-1:0] tot_bits;
        logic [TXV_W-1:0] tx_sh;
        logic [DW-1:0]    rx_word;
    } seq_s;

    localparam seq_s SEQ_RST = '{st: ST_IDLE, sclk: 1'b0, cs_n: 1'b1, gap_half: 1'b0,
                                 rx_en: 1'b0, bit_idx: '0, tx_bits: '0, tot_bits: '0,
                                 tx_sh: '0, rx_word: '0};

    seq_s q, d;

    logic [CW-1:0]    tx_n, rx_n;
    logic [BIT_W-1:0] tx_bits_n, tot_bits_n;
    logic [TXV_W-1:0] tx_vec;
    logic [RXP_W-1:0] rx_rel, rx_pos;

    // send order: opcode, address high to low, then data bytes low to high
    for (genvar k = 0; k < MAX_TX; k++) begin : g_txb
        if (k == 0) begin : g_op
            assign tx_vec[TXV_W-1-8*k -: 8] = cmd_word[7:0];
        end else if (k < 4) begin : g_adr
            assign tx_vec[TXV_W-1-8*k -: 8] = cmd_word[8*(4-k) +: 8];
        end else begin : g_dat
            assign tx_vec[TXV_W-1-8*k -: 8] = data_word[8*(k-4) +: 8];
        end
    end

    always_comb begin
        tx_n       = (tx_cnt > CW'(MAX_TX)) ? CW'(MAX_TX) : tx_cnt;
        rx_n       = (rx_cnt > CW'(MAX_RX)) ? CW'(MAX_RX) : rx_cnt;
        tx_bits_n  = BIT_W'(tx_n) << 3;
        tot_bits_n = (BIT_W'(tx_n) + BIT_W'(rx_n)) << 3;
        rx_rel     = RXP_W'(q.bit_idx - q.tx_bits);
        rx_pos     = {rx_rel[RXP_W-1:3], ~rx_rel[2:0]};
    end

    always_comb begin
        d       = q;
        rx_load = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st       = ST_SHIFT;
                    d.cs_n     = 1'b0;
                    d.sclk     = 1'b0;
                    d.gap_half = 1'b0;
                    d.bit_idx  = '0;
                    d.tx_bits  = tx_bits_n;
                    d.tot_bits = tot_bits_n;
                    d.rx_en    = (rx_n != '0);
                    d.tx_sh    = tx_vec;
                    d.rx_word  = '0;
                end
            end
            ST_SHIFT: begin
                if (tick) begin
                    if (!q.sclk) begin
                        d.sclk = 1'b1;
                        if (q.bit_idx >= q.tx_bits) begin
                            d.rx_word[rx_pos] = spi_miso;
                        end
                    end else begin
                        d.sclk    = 1'b0;
                        d.bit_idx = q.bit_idx + BIT_W'(1);
                        d.tx_sh   = q.tx_sh << 1;
                        if (q.bit_idx == q.tot_bits - BIT_W'(1)) begin
                            d.st   = ST_GAP;
                            d.cs_n = 1'b1;
                        end
                    end
                end
            end
            ST_GAP: begin
                if (tick) begin
                    if (q.gap_half) begin
                        d.st    = ST_IDLE;
                        rx_load = q.rx_en;
                    end else begin
                        d.gap_half = 1'b1;
                    end
                end
            end
            default: d = SEQ_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= SEQ_RST;
        end else begin
            q <= d;
        end
    end

    assign busy    = (q.st != ST_IDLE);
    assign sclk    = q.sclk;
    assign cs_n    = q.cs_n;
    assign mosi    = (q.st == ST_SHIFT) && (q.bit_idx < q.tx_bits) && q.tx_sh[TXV_W-1];
    assign rx_word = q.rx_word;

    // checker: cycles spent deselected while still busy
    logic [5:0] chk_gap_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_gap_q <= '0;
        end else if (!(busy && cs_n)) begin
            chk_gap_q <= '0;
        end else if (chk_gap_q != '1) begin
            chk_gap_q <= chk_gap_q + 6'd1;
        end
    end

    // R3: an accepted start shows busy on the next clock
    assert_busy_on_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    // R9: chip select is high whenever the engine is idle
    assert_idle_deselect_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cs_n);

    // R7: no clock edges while the flash is deselected
    assert_sclk_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R9: a full SCLK period of deselect precedes the end of busy
    assert_gap_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (chk_gap_q >= (6'd2 << clk_sel)));
endmodule

// File: rtl/sflash_cmd_engine.sv
`timescale 1ns/1ps
module sflash_cmd_engine
    import sfe_pkg::*;
#(
    parameter int DW = WORD_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          spi_sclk,
    output logic          spi_cs_n,
    output logic          spi_mosi,
    input  logic          spi_miso
);
    ctrl_t         ctrl;
    logic [DW-1:0] cmd_word, data_word, rx_word;
    logic          start, busy, rx_load, tick;

    sfe_regs #(.DW(DW), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (busy),
        .rx_load   (rx_load),
        .rx_word   (rx_word),
        .start     (start),
        .ctrl      (ctrl),
        .cmd_word  (cmd_word),
        .data_word (data_word)
    );

    sfe_clkdiv #(.SEL_W(SEL_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .sel   (ctrl.clk_sel),
        .tick  (tick)
    );

    sfe_shifter #(
        .DW     (DW),
        .MAX_TX (TX_BYTES_MAX),
        .MAX_RX (RX_BYTES_MAX),
        .CW     (CNT_W),
        .SW     (SEL_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .tx_cnt    (bus_wdata[3:0]),
        .rx_cnt    (bus_wdata[7:4]),
        .cmd_word  (cmd_word),
        .data_word (data_word),
        .tick      (tick),
        .clk_sel   (ctrl.clk_sel),
        .spi_miso  (spi_miso),
        .busy      (busy),
        .sclk      (spi_sclk),
        .cs_n      (spi_cs_n),
        .mosi      (spi_mosi),
        .rx_load   (rx_load),
        .rx_word   (rx_word)
    );
endmodule

// File: tb/sflash_cmd_engine_test.sv
`timescale 1ns/1ps
module sflash_cmd_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        spi_sclk, spi_cs_n, spi_mosi;
    logic        spi_miso = 1'b0;

    int n_checks = 0;
    int n_fail = 0;

    logic [95:0] resp_stream = '0;
    logic [95:0] cap_stream = '0;
    int nbits = 0;
    int cs_falls = 0;
    int rises_hi = 0;
    realtime prev_rise = 0.0;
    realtime period_ns = 0.0;
    realtime cs_rise_t = 0.0;
    realtime busy_fall_t = 0.0;

    always #2 clk = ~clk;

    sflash_cmd_engine uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // flash model: capture MOSI on rising SCLK, present the next MISO bit
    always @(posedge spi_sclk) begin
        if (spi_cs_n) rises_hi++;
        if (nbits < 96) cap_stream[95-nbits] = spi_mosi;
        nbits++;
        spi_miso = (nbits < 96) ? resp_stream[95-nbits] : 1'b0;
        period_ns = $realtime - prev_rise;
        prev_rise = $realtime;
    end

    always @(negedge spi_cs_n) begin
        cs_falls++;
        nbits = 0;
        spi_miso = resp_stream[95];
    end

    always @(posedge spi_cs_n) cs_rise_t = $realtime;

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = 32'h0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #0.5;
        v = bus_rdata;
    endtask

    task automatic wait_idle();
        logic done = 1'b0;
        for (int i = 0; i < 5000 && !done; i++) begin
            @(negedge clk);
            bus_addr = 4'h0;
            #0.5;
            if (!bus_rdata[16]) begin
                done = 1'b1;
                busy_fall_t = $realtime - 2.5;
            end
        end
        check_eq("R3 busy clears", {31'd0, done}, 32'd1);
    endtask

    // start a command; busy is read in the cycle after the write edge
    task automatic start_cmd(input logic [3:0] tx, input logic [3:0] rx, input logic [1:0] sel,
                             input logic exp_busy, input string req);
        @(negedge clk);
        bus_addr = 4'h0;
        bus_wdata = {6'd0, sel, 15'd0, 1'b1, rx, tx};
        bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = 32'h0;
        #0.5;
        check_eq(req, {31'd0, bus_rdata[16]}, {31'd0, exp_busy});
    endtask

    function automatic logic [7:0] cap_byte(input int k);
        return cap_stream[95-8*k -: 8];
    endfunction

    function automatic logic [7:0] exp_tx(input int k, input logic [31:0] c, input logic [31:0] dw);
        if (k == 0) return c[7:0];
        if (k < 4) return c[8*(4-k) +: 8];
        return dw[8*(k-4) +: 8];
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        rd(4'h0, v); check_eq("R1 ctrl reset", v, 32'h0);
        rd(4'h4, v); check_eq("R1 cmd reset", v, 32'h0);
        rd(4'h8, v); check_eq("R1 data reset", v, 32'h0);
        check_eq("R1 cs high", {31'd0, spi_cs_n}, 32'd1);
        check_eq("R1 sclk low", {31'd0, spi_sclk}, 32'd0);
    endtask

    task automatic t_regmap();
        logic [31:0] v;
        wr(4'h0, 32'hFFFF_FEF0);
        rd(4'h0, v); check_eq("R2 ctrl fields", v, 32'h0306_00F0);
        wr(4'h4, 32'hA5C3_0F96);
        rd(4'h4, v); check_eq("R2 cmd rw", v, 32'hA5C3_0F96);
        wr(4'h8, 32'h1234_5678);
        rd(4'h8, v); check_eq("R2 data rw", v, 32'h1234_5678);
    endtask

    task automatic t_zero_tx();
        int f0 = cs_falls;
        logic [31:0] v;
        start_cmd(4'd0, 4'd2, 2'd0, 1'b0, "R4 no busy");
        repeat (20) @(negedge clk);
        rd(4'h0, v);
        check_eq("R4 still idle", {31'd0, v[16]}, 32'd0);
        check_eq("R4 no cs activity", cs_falls - f0, 0);
        check_eq("R4 cs high", {31'd0, spi_cs_n}, 32'd1);
    endtask

    task automatic t_single();
        logic [31:0] v;
        wr(4'h4, 32'h0000_0006);
        wr(4'h8, 32'h5555_AAAA);
        start_cmd(4'd1, 4'd0, 2'd0, 1'b1, "R3 busy next clock");
        wait_idle();
        check_eq("R5 one byte bits", nbits, 8);
        check_eq("R5 opcode", {24'd0, cap_byte(0)}, 32'h06);
        check_eq("R8 sel0 period ns", int'(period_ns), 8);
        rd(4'h8, v); check_eq("R6 rx0 keeps data", v, 32'h5555_AAAA);
        rd(4'h0, v); check_eq("R2 start reads 0", {31'd0, v[8]}, 32'd0);
    endtask

    task automatic t_sig_read();
        logic [31:0] v;
        resp_stream = {32'h0, 8'h14, 8'h77, 8'h88, 8'h99, 32'h0};
        wr(4'h4, 32'h0000_00AB);
        start_cmd(4'd4, 4'd1, 2'd1, 1'b1, "R3 busy sig");
        wait_idle();
        check_eq("R5 sig opcode", {24'd0, cap_byte(0)}, 32'hAB);
        check_eq("R5 sig addr", {8'd0, cap_byte(1), cap_byte(2), cap_byte(3)}, 32'h0);
        check_eq("R6 mosi low in rx", {24'd0, cap_byte(4)}, 32'h0);
        check_eq("R8 sel1 period ns", int'(period_ns), 16);
        rd(4'h8, v); check_eq("R6 one byte zero fill", v, 32'h0000_0014);
    endtask

    task automatic t_program();
        logic [31:0] c = 32'h1234_5602;
        logic [31:0] dw = 32'hDDCC_BBAA;
        wr(4'h4, c);
        wr(4'h8, dw);
        start_cmd(4'd8, 4'd0, 2'd2, 1'b1, "R3 busy prog");
        wait_idle();
        check_eq("R5 prog bits", nbits, 64);
        for (int k = 0; k < 8; k++)
            check_eq("R5 prog byte", {24'd0, cap_byte(k)}, {24'd0, exp_tx(k, c, dw)});
        check_eq("R8 sel2 period ns", int'(period_ns), 32);
    endtask

    task automatic t_read4();
        logic [31:0] v;
        resp_stream = {32'h0, 8'h11, 8'h22, 8'h33, 8'h44, 32'h0};
        wr(4'h4, 32'hABCD_EF03);
        start_cmd(4'd4, 4'd4, 2'd3, 1'b1, "R3 busy read");
        wait_idle();
        check_eq("R5 read hdr", {cap_byte(0), cap_byte(1), cap_byte(2), cap_byte(3)}, 32'h03AB_CDEF);
        check_eq("R8 sel3 period ns", int'(period_ns), 64);
        check_eq("R9 cs after last edge", {31'd0, cs_rise_t > prev_rise}, 32'd1);
        check_eq("R9 gap ns", {31'd0, (busy_fall_t - cs_rise_t) >= 64.0}, 32'd1);
        rd(4'h8, v); check_eq("R6 little endian", v, 32'h4433_2211);
    endtask

    task automatic t_clamp();
        logic [31:0] v;
        logic [31:0] c = 32'h89AB_CD5A;
        logic [31:0] dw = 32'h7654_3210;
        resp_stream = {64'h0, 8'hC1, 8'hC2, 8'hC3, 8'hC4};
        wr(4'h4, c);
        wr(4'h8, dw);
        start_cmd(4'd15, 4'd15, 2'd0, 1'b1, "R3 busy clamp");
        wait_idle();
        check_eq("R5 R6 clamp bits", nbits, 96);
        check_eq("R5 clamp last tx", {24'd0, cap_byte(7)}, {24'd0, exp_tx(7, c, dw)});
        rd(4'h8, v); check_eq("R6 clamp rx", v, 32'hC4C3_C2C1);
    endtask

    task automatic t_lock();
        logic [31:0] v;
        int f0;
        wr(4'h4, 32'h0000_00C7);
        wr(4'h8, 32'h0BAD_F00D);
        f0 = cs_falls;
        start_cmd(4'd1, 4'd0, 2'd3, 1'b1, "R3 busy lock");
        wr(4'h4, 32'hFFFF_FFFF);
        wr(4'h8, 32'hDEAD_BEEF);
        wr(4'h0, 32'h0000_0142);
        wait_idle();
        rd(4'h4, v); check_eq("R10 cmd frozen", v, 32'h0000_00C7);
        rd(4'h8, v); check_eq("R10 data frozen", v, 32'h0BAD_F00D);
        rd(4'h0, v); check_eq("R10 ctrl frozen", v, 32'h0300_0001);
        check_eq("R10 one command", cs_falls - f0, 1);
        check_eq("R10 bit count", nbits, 8);
        check_eq("R7 sclk idle low", {31'd0, spi_sclk}, 32'd0);
        check_eq("R7 no sclk while deselected", rises_hi, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regmap();
        t_zero_tx();
        t_single();
        t_sig_read();
        t_program();
        t_read4();
        t_clamp();
        t_lock();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #800000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule